// File: doc/BRIEF.md
# Signed Decimal Adder-Subtractor

This block adds or subtracts two signed decimal numbers. Each number is held as packed BCD, four bits per digit, in ten's-complement form. A value counts as negative when its top digit is five or more. A single mode bit selects the operation. For subtraction, each digit of the second operand is replaced by nine minus that digit, and a carry of one enters the lowest digit.

The per-digit carry decision is made in two steps. First, a generate term and a propagate term are formed for each digit position. These feed a chain of 2-to-1 multiplexers that resolves the decimal carry into every digit. Each output digit is then a four-bit binary sum. When the chain reports a decimal carry out of that digit, the upper three bits of the sum get an add-six correction. Both operands are also widened by one sign digit (0 or 9). Overflow is found by comparing the sign meaning of that extra result digit with the sign meaning of the top real digit.

The arithmetic itself is combinational. A single register stage, cleared by an active-low asynchronous reset, holds the result, carry and overflow outputs.

Top module: `bcd_addsub`

## Requirements
- R1: With `sub_i` = 0, `result_o` equals (a + b) mod 10^DIGITS as packed BCD, with digit k in bits [4k+3:4k].
- R2: With `sub_i` = 1, `result_o` equals (a − b) mod 10^DIGITS as packed BCD. A number minus itself gives all-zero digits.
- R3: `overflow_o` is 1 exactly when the signed result lies outside the range −5·10^(DIGITS−1) to 5·10^(DIGITS−1)−1. An operand or result is negative when its top digit is 5 or more. This includes operations on the most negative value.
- R4: `carry_o` is the decimal carry out of the top digit. For addition it is 1 when the unsigned sum is at least 10^DIGITS. For subtraction it is 1 when unsigned a ≥ unsigned b.
- R5: When every input digit is 0 to 9, every digit of `result_o` is 0 to 9.
- R6: Outputs appear on the clock edge after the inputs are applied. While `rst_ni` is low, `result_o`, `carry_o` and `overflow_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sub_i | input | 1 | 0: add, 1: subtract |
| a_i | input | 4*DIGITS | First operand, packed BCD, ten's complement |
| b_i | input | 4*DIGITS | Second operand, packed BCD, ten's complement |
| result_o | output | 4*DIGITS | Registered BCD result |
| carry_o | output | 1 | Registered decimal carry out of the top digit |
| overflow_o | output | 1 | Registered signed overflow flag |

## Verification
Every result, carry and overflow value is due one clock edge after its operands and mode are applied, because there is one output register. The bench changes the inputs on a falling edge. It then waits a full cycle and reads the outputs on the next falling edge, well clear of the capturing rising edge. The sweep covers every pair of two-digit operands in both modes. The expected values come from integer arithmetic modulo 100 on the signed values.

// File: rtl/bcd_as_pkg.sv
package bcd_as_pkg;
  localparam int unsigned DIGIT_W = 4;
  typedef logic [DIGIT_W-1:0] digit_t;

  function automatic logic digit_neg(digit_t d);
    return d >= 4'd5;
  endfunction

  function automatic digit_t nines(digit_t d);
    return 4'd9 - d;
  endfunction
endpackage

// File: rtl/bcd_gp_cell.sv
module bcd_gp_cell
  import bcd_as_pkg::*;
#(
  parameter bit DIRECT_SUB = 1'b1
) (
  input  digit_t a_i,
  input  digit_t b_i,
  input  logic   sub_i,
  output logic   gen_o,
  output logic   prop_o
);
  logic [4:0] add_sum;
  assign add_sum = {1'b0, a_i} + {1'b0, b_i};

  generate
    if (DIRECT_SUB) begin : g_direct
      // a + (9-b) >= 10 <=> a > b ; a + (9-b) == 9 <=> a == b
      always_comb begin
        if (sub_i) begin
          gen_o  = a_i > b_i;
          prop_o = a_i == b_i;
        end else begin
          gen_o  = add_sum >= 5'd10;
          prop_o = add_sum == 5'd9;
        end
      end
    end else begin : g_via_nines
      logic [4:0] eff_sum;
      assign eff_sum = {1'b0, a_i} + {1'b0, (sub_i ? nines(b_i) : b_i)};
      always_comb begin
        gen_o  = eff_sum >= 5'd10;
        prop_o = eff_sum == 5'd9;
      end
    end
  endgenerate
endmodule

// File: rtl/bcd_carry_chain.sv
module bcd_carry_chain #(
  parameter int unsigned DIGITS = 4
) (
  input  logic [DIGITS-1:0] gen_i,
  input  logic [DIGITS-1:0] prop_i,
  input  logic              cin_i,
  output logic [DIGITS:0]   carry_o
);
  assign carry_o[0] = cin_i;
  for (genvar i = 0; i < DIGITS; i++) begin : g_link
    assign carry_o[i+1] = prop_i[i] ? carry_o[i] : gen_i[i];
  end
endmodule

// File: rtl/bcd_sum_cell.sv
module bcd_sum_cell
  import bcd_as_pkg::*;
(
  input  digit_t a_i,
  input  digit_t bx_i,
  input  logic   cin_i,
  input  logic   dcarry_i,
  output digit_t digit_o
);
  digit_t bin_sum;
  assign bin_sum = a_i + bx_i + {3'b000, cin_i};
  // +6 touches only bits [3:1]
  assign digit_o = {bin_sum[3:1] + (dcarry_i ? 3'd3 : 3'd0), bin_sum[0]};
endmodule

// File: rtl/bcd_sign_ext.sv
module bcd_sign_ext
  import bcd_as_pkg::*;
#(
  parameter int unsigned DIGITS = 4
) (
  input  logic [DIGIT_W*DIGITS-1:0]     num_i,
  output logic [DIGIT_W*(DIGITS+1)-1:0] ext_o
);
  assign ext_o = {(digit_neg(num_i[DIGIT_W*DIGITS-1 -: DIGIT_W]) ? 4'd9 : 4'd0), num_i};
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_as_pkg::*;
#(
  parameter int unsigned DIGITS     = 4,
  parameter bit          DIRECT_SUB = 1'b1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      sub_i,
  input  logic [DIGIT_W*DIGITS-1:0] a_i,
  input  logic [DIGIT_W*DIGITS-1:0] b_i,
  output logic [DIGIT_W*DIGITS-1:0] result_o,
  output logic                      carry_o,
  output logic                      overflow_o
);
  localparam int unsigned W   = DIGIT_W * DIGITS;
  localparam int unsigned EXT = DIGITS + 1;
  localparam int unsigned EW  = DIGIT_W * EXT;

  logic [EW-1:0]     a_ext, b_ext, sum_ext;
  logic [DIGITS-1:0] gen, prop;
  logic [DIGITS:0]   chain;

  bcd_sign_ext #(.DIGITS(DIGITS)) u_ext_a (.num_i(a_i), .ext_o(a_ext));
  bcd_sign_ext #(.DIGITS(DIGITS)) u_ext_b (.num_i(b_i), .ext_o(b_ext));

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    digit_t a_d, b_d, bx_d, s_d;
    assign a_d  = a_i[DIGIT_W*i +: DIGIT_W];
    assign b_d  = b_i[DIGIT_W*i +: DIGIT_W];
    assign bx_d = sub_i ? nines(b_d) : b_d;

    bcd_gp_cell #(.DIRECT_SUB(DIRECT_SUB)) u_gp (
      .a_i(a_d), .b_i(b_d), .sub_i(sub_i), .gen_o(gen[i]), .prop_o(prop[i])
    );
    bcd_sum_cell u_sum (
      .a_i(a_d), .bx_i(bx_d), .cin_i(chain[i]), .dcarry_i(chain[i+1]), .digit_o(s_d)
    );
    assign sum_ext[DIGIT_W*i +: DIGIT_W] = s_d;
  end

  bcd_carry_chain #(.DIGITS(DIGITS)) u_chain (
    .gen_i(gen), .prop_i(prop), .cin_i(sub_i), .carry_o(chain)
  );

  // sign digit: carry out of it is never needed, so decide its correction locally
  digit_t a_top, bx_top, top_d;
  logic [4:0] top_raw;
  assign a_top   = a_ext[EW-1 -: DIGIT_W];
  assign bx_top  = sub_i ? nines(b_ext[EW-1 -: DIGIT_W]) : b_ext[EW-1 -: DIGIT_W];
  assign top_raw = {1'b0, a_top} + {1'b0, bx_top} + {4'b0, chain[DIGITS]};

  bcd_sum_cell u_sum_top (
    .a_i(a_top), .bx_i(bx_top), .cin_i(chain[DIGITS]),
    .dcarry_i(top_raw >= 5'd10), .digit_o(top_d)
  );
  assign sum_ext[EW-1 -: DIGIT_W] = top_d;

  logic ovf_next;
  assign ovf_next = digit_neg(top_d) != digit_neg(sum_ext[W-1 -: DIGIT_W]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o   <= '0;
      carry_o    <= 1'b0;
      overflow_o <= 1'b0;
    end else begin
      result_o   <= sum_ext[W-1:0];
      carry_o    <= chain[DIGITS];
      overflow_o <= ovf_next;
    end
  end

  // ---------------- assertions ----------------
  logic in_valid;
  always_comb begin
    in_valid = 1'b1;
    for (int k = 0; k < DIGITS; k++) begin
      if (a_i[DIGIT_W*k +: DIGIT_W] > 4'd9 || b_i[DIGIT_W*k +: DIGIT_W] > 4'd9) in_valid = 1'b0;
    end
  end

  for (genvar k = 0; k < DIGITS; k++) begin : g_chk
    assert_digit_bcd_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_valid |=> result_o[DIGIT_W*k +: DIGIT_W] <= 4'd9);
  end

  assert_self_diff_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_i && a_i == b_i) |=> (result_o == '0 && carry_o && !overflow_o));

  assert_add_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sub_i && b_i == '0) |=> (result_o == $past(a_i) && !carry_o && !overflow_o));

  assert_sub_carry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sub_i && in_valid) |=> (carry_o == ($past(a_i) >= $past(b_i))));

  assert_ovf_signs_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |->
      (digit_neg($past(a_i[W-1 -: DIGIT_W])) == ($past(sub_i) ^ digit_neg($past(b_i[W-1 -: DIGIT_W]))))
      && (digit_neg(result_o[W-1 -: DIGIT_W]) != digit_neg($past(a_i[W-1 -: DIGIT_W]))));

  assert_reset_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (result_o == '0 && !carry_o && !overflow_o));
endmodule

// File: tb/bcd_addsub_test.sv
module bcd_addsub_test;
  localparam int N   = 2;
  localparam int W   = 4 * N;
  localparam int MOD = 100;
  localparam int HALF = 50;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         sub_i = 1'b0;
  logic [W-1:0] a_i = '0, b_i = '0;
  logic [W-1:0] result_o;
  logic         carry_o, overflow_o;

  int checks = 0;
  int fails  = 0;

  always #10 clk_i = ~clk_i;

  bcd_addsub #(.DIGITS(N)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sub_i(sub_i), .a_i(a_i), .b_i(b_i),
    .result_o(result_o), .carry_o(carry_o), .overflow_o(overflow_o)
  );

  function automatic logic [W-1:0] to_bcd(int v);
    logic [W-1:0] r;
    for (int i = 0; i < N; i++) begin
      r[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic int to_signed(int u);
    return (u >= HALF) ? u - MOD : u;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      if (fails <= 20) $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit digits_ok(logic [W-1:0] v);
    for (int i = 0; i < N; i++) if (v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  function automatic int from_bcd(logic [W-1:0] v);
    int r = 0;
    for (int i = N - 1; i >= 0; i--) r = r * 10 + int'(v[4*i +: 4]);
    return r;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R6: reset state
    repeat (2) @(negedge clk_i);
    check(result_o == '0 && !carry_o && !overflow_o, "R6 reset", int'(result_o), 0);
    rst_ni = 1'b1;

    for (int s = 0; s < 2; s++) begin
      for (int a = 0; a < MOD; a++) begin
        for (int b = 0; b < MOD; b++) begin
          int exact, exp_res;
          bit exp_ovf, exp_cy;
          @(negedge clk_i);
          sub_i = s[0];
          a_i   = to_bcd(a);
          b_i   = to_bcd(b);
          exact   = s ? to_signed(a) - to_signed(b) : to_signed(a) + to_signed(b);
          exp_res = ((exact % MOD) + MOD) % MOD;
          exp_ovf = (exact < -HALF) || (exact >= HALF);
          exp_cy  = s ? (a >= b) : (a + b >= MOD);
          @(negedge clk_i);  // one register stage (R6)
          check(digits_ok(result_o), "R5 digits", int'(result_o), 0);
          if (s == 0) check(from_bcd(result_o) == exp_res, "R1 sum", from_bcd(result_o), exp_res);
          else        check(from_bcd(result_o) == exp_res, "R2 difference", from_bcd(result_o), exp_res);
          check(carry_o == exp_cy, "R4 carry", int'(carry_o), int'(exp_cy));
          check(overflow_o == exp_ovf, "R3 overflow", int'(overflow_o), int'(exp_ovf));
        end
      end
    end

    // R3: most negative value negated overflows; R2: zero result
    @(negedge clk_i); sub_i = 1'b1; a_i = to_bcd(0); b_i = to_bcd(50);
    @(negedge clk_i);
    check(overflow_o && from_bcd(result_o) == 50, "R3 negate min", from_bcd(result_o), 50);
    @(negedge clk_i); sub_i = 1'b1; a_i = to_bcd(73); b_i = to_bcd(73);
    @(negedge clk_i);
    check(result_o == '0 && carry_o && !overflow_o, "R2 zero", from_bcd(result_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule